// File: doc/BRIEF.md
# Privileged status and trap controller

This block keeps the privileged control state of a processor core: a 64-bit status word, the saved exception PC, the trap vector, the trap cause, the captured faulting address, two scratch registers and a pair of host mailbox registers. Software reaches them through one indexed port. The write is clocked and the read is combinational. The pipeline supplies the current PC and the faulting address on inputs, and it raises synchronous exceptions with a cause code.

Interrupt-pending bits belong to hardware. Interrupt lines set and clear them, and a few mailbox registers also set or clear them. A software write to the status word never changes them. Each cycle the block compares the pending bits with the mask bits. It takes an interrupt only when traps are enabled, and the lowest-numbered request wins. On any trap it updates every trap register and the privilege bits at one clock edge, then presents the trap vector as a one-cycle redirect to fetch.

Top module: `priv_ctrl`

## Requirements
- R1: During reset and until the first clock edge after reset is released, `redirect_valid` is 1, `redirect_pc` is 0x2000 and `status` is 0x00FF00A0. One clock later `redirect_valid` is 0. All other registers read as 0.
- R2: The status word has these fields: TE (trap enable) bit 0, FE (float enable) bit 1, CE (compressed enable) bit 2, VE (vector enable) bit 3, PS (previous supervisor) bit 4, S (supervisor) bit 5, U64 bit 6, S64 bit 7, VM bit 8, mask field bits 23:16 and pending field bits 31:24. All other bits read as zero. A write to index 0 replaces bits 8:0 and 23:16, and it leaves the pending field unchanged.
- R3: The enable bit of a feature that is not implemented reads 0 after every write. With the default parameters, CE and VE are not implemented, and the 64-bit and float features are.
- R4: An interrupt is taken only when TE is 1 and the AND of the pending and mask fields is non-zero. The lowest-numbered set bit is taken. A pending interrupt takes priority over a synchronous exception raised in the same cycle.
- R5: At the clock edge of a trap, S becomes 1, PS takes the old value of S, TE becomes 0, and all other status fields are kept.
- R6: At the same edge, the cause (index 4) is loaded, the exception PC (index 1) takes `cur_pc`, the bad address (index 2) takes `bad_addr`, and `redirect_pc` takes the trap vector (index 3). `redirect_valid` is 1 for that one cycle.
- R7: The cause of an interrupt is the interrupt number in the low bits with bit 63 set. The cause of an exception is `exc_cause` unchanged.
- R8: A write to index 9 sets pending bit 5 when bit 0 of the data is 1 and clears it otherwise.
- R9: A write to index 11 stores the value. It sets pending bit 6 when the value is non-zero and clears it when the value is zero.
- R10: A write to index 10 is stored only while that register holds zero. The register is driven on the `tohost` output.
- R11: Index 7 reads the hart number (default 3) and index 8 reads 1. Indices 9 and 12 to 31 read all ones. Writes to indices 2, 4, 7 and 8 are ignored. Indices 5 and 6 are scratch registers that can be read and written.
- R12: A register write in the same cycle as a trap is dropped.
- R13: `irq_raise` sets pending bits and `irq_drop` clears them one clock later. Drop wins over raise. A same-cycle write to index 9 or 11 overrides that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_pc | input | 64 | PC of the instruction in flight |
| bad_addr | input | 64 | Faulting virtual address |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | 64 | Exception cause code |
| irq_raise | input | 8 | Set pending interrupt bits |
| irq_drop | input | 8 | Clear pending interrupt bits |
| csr_we | input | 1 | Register write strobe |
| csr_idx | input | 5 | Register index |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Read data for `csr_idx` |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 64 | Fetch target |
| status | output | 64 | Current status word |
| tohost | output | 64 | Host mailbox value |

## Verification
The read port is combinational. A write therefore shows on `csr_rdata` and `status` in the half-cycle after the edge that takes it. Pending-bit changes from the interrupt lines appear after one edge. An interrupt needs one edge to enable it through a status write and a second edge to enter the trap. The redirect pulse and all trap registers are valid after the entry edge and gone one edge later. The bench drives every input on the falling edge and samples on the falling edge that follows the edge at which each result is due.

// File: rtl/priv_pkg.sv
package priv_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned IDXW  = 5;
  localparam int unsigned NIRQ  = 8;

  localparam int unsigned ST_TE  = 0;
  localparam int unsigned ST_FE  = 1;
  localparam int unsigned ST_CE  = 2;
  localparam int unsigned ST_VE  = 3;
  localparam int unsigned ST_PS  = 4;
  localparam int unsigned ST_S   = 5;
  localparam int unsigned ST_U64 = 6;
  localparam int unsigned ST_S64 = 7;
  localparam int unsigned ST_VM  = 8;
  localparam int unsigned ST_IM_LO = 16;
  localparam int unsigned ST_IP_LO = 24;

  localparam int unsigned IRQ_IPI  = 5;
  localparam int unsigned IRQ_HOST = 6;

  typedef enum logic [IDXW-1:0] {
    RIX_STATUS   = 5'd0,
    RIX_EPC      = 5'd1,
    RIX_BADADDR  = 5'd2,
    RIX_EVEC     = 5'd3,
    RIX_CAUSE    = 5'd4,
    RIX_SCR0     = 5'd5,
    RIX_SCR1     = 5'd6,
    RIX_HART     = 5'd7,
    RIX_IMPL     = 5'd8,
    RIX_IPICLR   = 5'd9,
    RIX_TOHOST   = 5'd10,
    RIX_FROMHOST = 5'd11
  } reg_idx_e;

  // bits of the status body (everything but the pending field) that software may hold
  function automatic logic [XLEN-1:0] st_keep(input logic wide, input logic fpu,
                                              input logic rvc, input logic vec);
    logic [XLEN-1:0] m;
    m = '0;
    m[ST_VM:ST_TE] = '1;
    m[ST_IM_LO +: NIRQ] = '1;
    if (!wide) begin
      m[ST_U64] = 1'b0;
      m[ST_S64] = 1'b0;
    end
    if (!fpu) m[ST_FE] = 1'b0;
    if (!rvc) m[ST_CE] = 1'b0;
    if (!vec) m[ST_VE] = 1'b0;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] st_reset_word();
    logic [XLEN-1:0] r;
    r = '0;
    r[ST_S]   = 1'b1;
    r[ST_S64] = 1'b1;
    r[ST_IM_LO +: NIRQ] = '1;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] st_trap_entry(input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    r = b;
    r[ST_PS] = b[ST_S];
    r[ST_S]  = 1'b1;
    r[ST_TE] = 1'b0;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] irq_cause_code(input logic [$clog2(NIRQ)-1:0] num);
    logic [XLEN-1:0] c;
    c = '0;
    c[$clog2(NIRQ)-1:0] = num;
    c[XLEN-1] = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/priv_irq_pick.sv
module priv_irq_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  mask,
  input  logic          enable,
  output logic          fire,
  output logic [IW-1:0] num,
  output logic [N-1:0]  grant
);
  logic [N-1:0] act;

  assign act   = enable ? (pend & mask) : '0;
  assign grant = act & (~act + N'(1));
  assign fire  = |act;

  always_comb begin
    num = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) num = IW'(i);
    end
  end

  assert_grant_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($onehot(grant) && ((grant & ~pend) == '0) && ((grant & ~mask) == '0)));
  assert_grant_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (((grant - N'(1)) & pend & mask) == '0));
  assert_gate_on_te_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !fire);
endmodule

// File: rtl/priv_status_unit.sv
module priv_status_unit
  import priv_pkg::*;
#(
  parameter bit EN_WIDE     = 1'b1,
  parameter bit EN_FPU      = 1'b1,
  parameter bit EN_COMPRESS = 1'b0,
  parameter bit EN_VECTOR   = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_we,
  input  logic [XLEN-1:0] sw_wdata,
  input  logic            trap_fire,
  input  logic [NIRQ-1:0] hw_raise,
  input  logic [NIRQ-1:0] hw_drop,
  input  logic            ipi_we,
  input  logic            ipi_val,
  input  logic            host_we,
  input  logic            host_val,
  output logic [XLEN-1:0] status_o,
  output logic [NIRQ-1:0] ip_o,
  output logic [NIRQ-1:0] im_o,
  output logic            te_o
);
  localparam logic [XLEN-1:0] KEEP = st_keep(EN_WIDE, EN_FPU, EN_COMPRESS, EN_VECTOR);

  logic [XLEN-1:0] body_q, body_d;
  logic [NIRQ-1:0] ip_q, ip_d;

  always_comb begin
    ip_d = (ip_q | hw_raise) & ~hw_drop;
    if (ipi_we)  ip_d[IRQ_IPI]  = ipi_val;
    if (host_we) ip_d[IRQ_HOST] = host_val;
  end

  always_comb begin
    body_d = body_q;
    if (trap_fire)  body_d = st_trap_entry(body_q);
    else if (sw_we) body_d = sw_wdata & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      body_q <= st_reset_word() & KEEP;
      ip_q   <= '0;
    end else begin
      body_q <= body_d;
      ip_q   <= ip_d;
    end
  end

  assign status_o = {body_q[XLEN-1:ST_IP_LO+NIRQ], ip_q, body_q[ST_IP_LO-1:0]};
  assign ip_o     = ip_q;
  assign im_o     = body_q[ST_IM_LO +: NIRQ];
  assign te_o     = body_q[ST_TE];

  assert_trap_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> (!body_q[ST_TE] && body_q[ST_S] && (body_q[ST_PS] == $past(body_q[ST_S]))));
  assert_ip_survives_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !trap_fire && hw_raise == '0 && hw_drop == '0 && !ipi_we && !host_we)
      |=> $stable(ip_q));
  assert_raz_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[15:9] == '0) && (status_o[XLEN-1:32] == '0));
  assert_absent_feature_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (EN_COMPRESS || !status_o[ST_CE]) && (EN_VECTOR || !status_o[ST_VE]) &&
    (EN_FPU || !status_o[ST_FE]) && (EN_WIDE || (!status_o[ST_U64] && !status_o[ST_S64])));
endmodule

// File: rtl/priv_ctrl.sv
module priv_ctrl
  import priv_pkg::*;
#(
  parameter logic [63:0] RESET_PC    = 64'h2000,
  parameter logic [63:0] HART_ID     = 64'd3,
  parameter bit          EN_WIDE     = 1'b1,
  parameter bit          EN_FPU      = 1'b1,
  parameter bit          EN_COMPRESS = 1'b0,
  parameter bit          EN_VECTOR   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] cur_pc,
  input  logic [63:0] bad_addr,
  input  logic        exc_req,
  input  logic [63:0] exc_cause,
  input  logic [7:0]  irq_raise,
  input  logic [7:0]  irq_drop,
  input  logic        csr_we,
  input  logic [4:0]  csr_idx,
  input  logic [63:0] csr_wdata,
  output logic [63:0] csr_rdata,
  output logic        redirect_valid,
  output logic [63:0] redirect_pc,
  output logic [63:0] status,
  output logic [63:0] tohost
);
  localparam int unsigned IW = $clog2(NIRQ);

  logic [XLEN-1:0] epc_q, evec_q, cause_q, badaddr_q, scr0_q, scr1_q;
  logic [XLEN-1:0] tohost_q, fromhost_q, redir_pc_q;
  logic            redir_v_q;

  logic [NIRQ-1:0] ip, im, grant;
  logic            te;
  logic            irq_fire, trap_fire, wr_ok;
  logic [IW-1:0]   irq_num;
  logic            wr_status, wr_ipi, wr_host, wr_tohost;
  logic [XLEN-1:0] trap_cause;

  priv_irq_pick #(.N(NIRQ)) u_pick (
    .clk(clk), .rst_n(rst_n), .pend(ip), .mask(im), .enable(te),
    .fire(irq_fire), .num(irq_num), .grant(grant)
  );

  assign trap_fire  = irq_fire | exc_req;
  assign trap_cause = irq_fire ? irq_cause_code(irq_num) : exc_cause;
  assign wr_ok      = csr_we & ~trap_fire;
  assign wr_status  = wr_ok && (csr_idx == RIX_STATUS);
  assign wr_ipi     = wr_ok && (csr_idx == RIX_IPICLR);
  assign wr_host    = wr_ok && (csr_idx == RIX_FROMHOST);
  assign wr_tohost  = wr_ok && (csr_idx == RIX_TOHOST) && (tohost_q == '0);

  priv_status_unit #(
    .EN_WIDE(EN_WIDE), .EN_FPU(EN_FPU), .EN_COMPRESS(EN_COMPRESS), .EN_VECTOR(EN_VECTOR)
  ) u_status (
    .clk(clk), .rst_n(rst_n),
    .sw_we(wr_status), .sw_wdata(csr_wdata), .trap_fire(trap_fire),
    .hw_raise(irq_raise), .hw_drop(irq_drop),
    .ipi_we(wr_ipi), .ipi_val(csr_wdata[0]),
    .host_we(wr_host), .host_val(csr_wdata != '0),
    .status_o(status), .ip_o(ip), .im_o(im), .te_o(te)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q      <= '0;
      evec_q     <= '0;
      cause_q    <= '0;
      badaddr_q  <= '0;
      scr0_q     <= '0;
      scr1_q     <= '0;
      tohost_q   <= '0;
      fromhost_q <= '0;
      redir_v_q  <= 1'b1;
      redir_pc_q <= RESET_PC;
    end else begin
      redir_v_q <= trap_fire;
      if (trap_fire) begin
        cause_q    <= trap_cause;
        epc_q      <= cur_pc;
        badaddr_q  <= bad_addr;
        redir_pc_q <= evec_q;
      end else if (wr_ok) begin
        case (reg_idx_e'(csr_idx))
          RIX_EPC:      epc_q      <= csr_wdata;
          RIX_EVEC:     evec_q     <= csr_wdata;
          RIX_SCR0:     scr0_q     <= csr_wdata;
          RIX_SCR1:     scr1_q     <= csr_wdata;
          RIX_FROMHOST: fromhost_q <= csr_wdata;
          default: ;
        endcase
        if (wr_tohost) tohost_q <= csr_wdata;
      end
    end
  end

  always_comb begin
    case (reg_idx_e'(csr_idx))
      RIX_STATUS:   csr_rdata = status;
      RIX_EPC:      csr_rdata = epc_q;
      RIX_BADADDR:  csr_rdata = badaddr_q;
      RIX_EVEC:     csr_rdata = evec_q;
      RIX_CAUSE:    csr_rdata = cause_q;
      RIX_SCR0:     csr_rdata = scr0_q;
      RIX_SCR1:     csr_rdata = scr1_q;
      RIX_HART:     csr_rdata = HART_ID;
      RIX_IMPL:     csr_rdata = 64'd1;
      RIX_TOHOST:   csr_rdata = tohost_q;
      RIX_FROMHOST: csr_rdata = fromhost_q;
      default:      csr_rdata = '1;
    endcase
  end

  assign redirect_valid = redir_v_q;
  assign redirect_pc    = redir_pc_q;
  assign tohost         = tohost_q;

  assert_trap_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> (redirect_valid && redirect_pc == $past(evec_q) &&
                   epc_q == $past(cur_pc) && badaddr_q == $past(bad_addr)));
  assert_irq_cause_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fire |=> (cause_q[XLEN-1] && cause_q[IW-1:0] == $past(irq_num)));
  assert_exc_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !irq_fire) |=> (cause_q == $past(exc_cause)));
  assert_trap_beats_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> ($stable(scr0_q) && $stable(scr1_q) && $stable(evec_q) && $stable(fromhost_q)));
  assert_tohost_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tohost_q != '0) |=> $stable(tohost_q));
  assert_redirect_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_fire |=> !redirect_valid);
endmodule

// File: tb/sim_priv_ctrl.sv
module sim_priv_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cur_pc = '0, bad_addr = '0, exc_cause = '0, csr_wdata = '0;
  logic        exc_req = 1'b0, csr_we = 1'b0;
  logic [7:0]  irq_raise = '0, irq_drop = '0;
  logic [4:0]  csr_idx = '0;
  logic [63:0] csr_rdata, redirect_pc, status, tohost;
  logic        redirect_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic [63:0] EVEC = 64'h8000_1000;
  localparam logic [63:0] MSB  = 64'h8000_0000_0000_0000;

  always #4 clk = ~clk;

  priv_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .bad_addr(bad_addr),
    .exc_req(exc_req), .exc_cause(exc_cause), .irq_raise(irq_raise), .irq_drop(irq_drop),
    .csr_we(csr_we), .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .status(status), .tohost(tohost)
  );

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      report();
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] idx, input logic [63:0] val);
    csr_we = 1'b1; csr_idx = idx; csr_wdata = val;
    tick();
    csr_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [4:0] idx, input logic [63:0] exp);
    csr_idx = idx;
    #1;
    chk(tag, csr_rdata, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 redirect_valid in reset", {63'b0, redirect_valid}, 64'd1);
    chk("R1 redirect_pc in reset", redirect_pc, 64'h2000);
    chk("R1 status in reset", status, 64'h00FF_00A0);
    rst_n = 1'b1;
    tick();
    chk("R1 redirect drops", {63'b0, redirect_valid}, 64'd0);
    rd("R1 epc zero", 5'd1, 64'd0);
    rd("R1 tohost zero", 5'd10, 64'd0);
  endtask

  task automatic t_reads();
    rd("R11 unmapped 31", 5'd31, '1);
    rd("R11 unmapped 12", 5'd12, '1);
    rd("R11 ipi index reads ones", 5'd9, '1);
    rd("R11 impl", 5'd8, 64'd1);
    rd("R11 hart", 5'd7, 64'd3);
    wr(5'd8, 64'h5);
    rd("R11 impl write ignored", 5'd8, 64'd1);
    wr(5'd4, 64'h99);
    rd("R11 cause write ignored", 5'd4, 64'd0);
    wr(5'd2, 64'h42);
    rd("R11 badaddr write ignored", 5'd2, 64'd0);
  endtask

  task automatic t_hw_pend();
    irq_raise = 8'h04;
    tick();
    irq_raise = 8'h00;
    chk("R13 raise sets pending", status, 64'h04FF_00A0);
    irq_raise = 8'h0C; irq_drop = 8'h04;
    tick();
    irq_raise = 8'h00; irq_drop = 8'h00;
    chk("R13 drop beats raise", status, 64'h08FF_00A0);
  endtask

  task automatic t_status_wr();
    wr(5'd0, 64'hFFFF_FFFF_FF00_FFFF);
    chk("R2 R3 status write masks", status, 64'h0800_01F3);
    tick();
    chk("R4 masked interrupt not taken", {63'b0, redirect_valid}, 64'd0);
    wr(5'd0, 64'h0000_0000_00FF_00A0);
    chk("R2 status restore", status, 64'h08FF_00A0);
    tick();
    chk("R4 TE clear blocks interrupt", {63'b0, redirect_valid}, 64'd0);
    wr(5'd3, EVEC);
    rd("R6 evec readback", 5'd3, EVEC);
  endtask

  task automatic t_irq();
    irq_raise = 8'h40;
    tick();
    irq_raise = 8'h00;
    wr(5'd0, 64'h0040_0081);
    chk("R2 user mode status", status, 64'h4840_0081);
    cur_pc = 64'h1234; bad_addr = 64'hBAD0;
    exc_req = 1'b1; exc_cause = 64'h5;
    tick();
    exc_req = 1'b0;
    chk("R6 redirect after interrupt", {63'b0, redirect_valid}, 64'd1);
    chk("R6 redirect pc is vector", redirect_pc, EVEC);
    rd("R7 R4 interrupt cause", 5'd4, MSB | 64'd6);
    rd("R6 epc captured", 5'd1, 64'h1234);
    rd("R6 badaddr captured", 5'd2, 64'hBAD0);
    chk("R5 status after interrupt", status, 64'h4840_00A0);
    tick();
    chk("R6 redirect one cycle", {63'b0, redirect_valid}, 64'd0);
  endtask

  task automatic t_sync_trap();
    cur_pc = 64'h4444; bad_addr = 64'h77;
    exc_req = 1'b1; exc_cause = 64'hD;
    csr_we = 1'b1; csr_idx = 5'd5; csr_wdata = 64'hAAAA;
    tick();
    exc_req = 1'b0; csr_we = 1'b0;
    rd("R7 exception cause", 5'd4, 64'hD);
    rd("R6 epc sync", 5'd1, 64'h4444);
    rd("R6 badaddr sync", 5'd2, 64'h77);
    chk("R5 PS from S", status, 64'h4840_00B0);
    rd("R12 write dropped on trap", 5'd5, 64'd0);
    wr(5'd5, 64'hAAAA);
    rd("R11 scratch0", 5'd5, 64'hAAAA);
    wr(5'd6, 64'h5555);
    rd("R11 scratch1", 5'd6, 64'h5555);
  endtask

  task automatic t_lowest();
    wr(5'd0, 64'h0048_0021);
    cur_pc = 64'h9000;
    tick();
    rd("R4 lowest pending wins", 5'd4, MSB | 64'd3);
    chk("R5 status after second interrupt", status, 64'h4848_0030);
    chk("R6 redirect pc again", redirect_pc, EVEC);
  endtask

  task automatic t_ipi();
    wr(5'd9, 64'h1);
    chk("R8 ipi set", status, 64'h6848_0030);
    wr(5'd9, 64'h2);
    chk("R8 ipi cleared by bit0", status, 64'h4848_0030);
    irq_raise = 8'h20;
    wr(5'd9, 64'h0);
    irq_raise = 8'h00;
    chk("R13 software overrides raise", status, 64'h4848_0030);
  endtask

  task automatic t_host();
    irq_drop = 8'h40;
    tick();
    irq_drop = 8'h00;
    chk("R13 drop host bit", status, 64'h0848_0030);
    wr(5'd11, 64'h9);
    chk("R9 fromhost sets pending", status, 64'h4848_0030);
    rd("R9 fromhost value", 5'd11, 64'h9);
    wr(5'd11, 64'h0);
    chk("R9 fromhost zero clears", status, 64'h0848_0030);
  endtask

  task automatic t_tohost();
    wr(5'd10, 64'h55);
    chk("R10 tohost accepted", tohost, 64'h55);
    wr(5'd10, 64'h77);
    chk("R10 tohost held", tohost, 64'h55);
    rd("R10 tohost read", 5'd10, 64'h55);
  endtask

  initial begin
    t_reset();
    t_reads();
    t_hw_pend();
    t_status_wr();
    t_irq();
    t_sync_trap();
    t_lowest();
    t_ipi();
    t_host();
    t_tohost();
    report();
  end
endmodule